// File: doc/BRIEF.md
# Deflection Router Eject and Inject Stage

This block is the front stage of a deflection router with four flit slots. Each cycle it looks at the flits arriving on its slots. It removes at most one flit addressed to this node and sends it out on an ejection port. It then fills the slots left empty, first with a flit taken back from the router's side buffer and then with a new flit from the local node. The result is registered and handed to the routing stage one cycle later. The flit in each slot stays in that slot, and its age goes up by one.

The side-buffer source and the local source are valid/ready streams, and a flit is taken only in a cycle where valid and ready are both high. Ready depends only on slot occupancy and the starvation state, never on the source's own valid, so a source may hold valid high for as long as it likes.

The ejection port, the displaced-flit port and the slot outputs cannot be stalled. Whatever sits downstream must take them every cycle.

If the side-buffer head goes without a free slot for too long, the stage forces a slot open. It pushes out the flit in slot 0 on the displaced-flit port so that the side buffer can store it, and it places the waiting flit in its place. This keeps buffered flits from waiting forever.

Top module: `defl_eject_inject`

## Requirements
- R1: A flit word is {dest x[3], dest y[3], age[4], payload[8]}, MSB first. A valid slot whose dest x and y both equal `node_x` and `node_y` is a local flit. When one or more local flits are present, exactly one of them appears on `ej_flit` with `ej_valid` high one cycle later. Otherwise `ej_valid` is low.
- R2: Among several local flits, the one with the largest age is ejected. When ages are equal, the lowest slot index wins.
- R3: A local flit that is not ejected, and any non-local flit, keeps its slot index on the output.
- R4: `sb_ready` is high when a free slot exists after ejection. A free slot is an input slot that is invalid or whose flit was ejected. An accepted side-buffer flit goes into the lowest-index free slot.
- R5: `inj_ready` is high when a free slot is still left after the side-buffer flit has taken its slot. The side-buffer flit takes a slot only if `sb_valid` and `sb_ready` are both high. An accepted local flit goes into the lowest-index slot that is still free.
- R6: When every slot holds a flit and none is ejected, `inj_ready` is low. `sb_ready` is also low unless redirection is due (R7).
- R7: If `sb_valid` has been high for STARVE_LIMIT consecutive cycles without acceptance (default 3), then on the next cycle with no free slot `sb_ready` rises. In that case the flit in slot 0 leaves on `disp_flit` with `disp_valid` high and its age unchanged, and the side-buffer flit takes slot 0.
- R8: The age of every flit in a valid output slot is its input age plus one, and it saturates at 15.
- R9: While `rst_n` is low, `out_valid`, `ej_valid` and `disp_valid` are all low.
- R10: All outputs are registered one cycle after the inputs they reflect. An output slot is valid exactly when it carried a non-ejected input flit or received an injected flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_x | input | 3 | Local node x coordinate |
| node_y | input | 3 | Local node y coordinate |
| in_valid | input | NPORTS | Occupancy of incoming slots |
| in_flit | input | NPORTS x 18 | Incoming slot flits |
| sb_valid | input | 1 | Side-buffer head flit present |
| sb_flit | input | 18 | Side-buffer head flit |
| sb_ready | output | 1 | Side-buffer flit accepted this cycle if valid |
| inj_valid | input | 1 | Local node has a flit to send |
| inj_flit | input | 18 | Local node flit |
| inj_ready | output | 1 | Local flit accepted this cycle if valid |
| ej_valid | output | 1 | Ejected flit present |
| ej_flit | output | 18 | Ejected flit |
| disp_valid | output | 1 | Displaced flit for the side buffer |
| disp_flit | output | 18 | Displaced flit |
| out_valid | output | NPORTS | Occupancy of outgoing slots |
| out_flit | output | NPORTS x 18 | Outgoing slot flits with aged counters |

## Verification
The bench puts several local flits in competition, with distinct ages and with tied ages. A picker that compares ages the wrong way, or breaks ties toward the higher index, would eject the wrong payload. The bench also fills every slot, empties exactly one by ejection, and offers both sources in the same cycle, so a design that lets local traffic ahead of the side buffer, or puts both flits in one slot, shows up as a wrong ready or a wrong slot. It feeds an age of 15 to catch a counter that wraps. It then starves the side buffer across the redirection boundary to catch an off-by-one in the wait count, or a displaced flit that goes missing or gets aged.

// File: rtl/defl_ei_pkg.sv
package defl_ei_pkg;
  localparam int COORD_W = 3;
  localparam int AGE_W   = 4;
  localparam int DATA_W  = 8;
  localparam int FLIT_W  = 2 * COORD_W + AGE_W + DATA_W;

  typedef struct packed {
    logic [COORD_W-1:0] dx;
    logic [COORD_W-1:0] dy;
    logic [AGE_W-1:0]   age;
    logic [DATA_W-1:0]  data;
  } flit_t;
endpackage

// File: rtl/defl_oldest_pick.sv
module defl_oldest_pick import defl_ei_pkg::*; #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0]            cand,
  input  logic [NP-1:0][AGE_W-1:0] age,
  output logic                     hit,
  output logic [IW-1:0]            idx
);
  logic [AGE_W-1:0] best;
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NP; i++) begin
      // strict compare keeps the lower index on a tie
      if (cand[i] && (!hit || age[i] > best)) begin
        hit  = 1'b1;
        idx  = IW'(i);
        best = age[i];
      end
    end
  end
endmodule

// File: rtl/defl_low_free.sv
module defl_low_free #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0] mask,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |mask;
    idx = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/defl_eject_inject.sv
module defl_eject_inject import defl_ei_pkg::*; #(
  parameter int NPORTS       = 4,
  parameter int STARVE_LIMIT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [COORD_W-1:0]            node_x,
  input  logic [COORD_W-1:0]            node_y,
  input  logic [NPORTS-1:0]             in_valid,
  input  logic [NPORTS-1:0][FLIT_W-1:0] in_flit,
  input  logic                          sb_valid,
  input  logic [FLIT_W-1:0]             sb_flit,
  output logic                          sb_ready,
  input  logic                          inj_valid,
  input  logic [FLIT_W-1:0]             inj_flit,
  output logic                          inj_ready,
  output logic                          ej_valid,
  output logic [FLIT_W-1:0]             ej_flit,
  output logic                          disp_valid,
  output logic [FLIT_W-1:0]             disp_flit,
  output logic [NPORTS-1:0]             out_valid,
  output logic [NPORTS-1:0][FLIT_W-1:0] out_flit
);
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int CW = $clog2(STARVE_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STARVE_LIMIT);

  flit_t                        slot_f [NPORTS];
  logic [NPORTS-1:0]            is_local;
  logic [NPORTS-1:0][AGE_W-1:0] age_v;

  for (genvar g = 0; g < NPORTS; g++) begin : g_slot
    assign slot_f[g]   = flit_t'(in_flit[g]);
    assign is_local[g] = in_valid[g] && (slot_f[g].dx == node_x) && (slot_f[g].dy == node_y);
    assign age_v[g]    = slot_f[g].age;
  end

  // ejection choice
  logic          ej_hit;
  logic [IW-1:0] ej_idx;
  defl_oldest_pick #(.NP(NPORTS)) u_eject (
    .cand(is_local), .age(age_v), .hit(ej_hit), .idx(ej_idx)
  );

  logic [NPORTS-1:0] free_v, free_rest;
  always_comb begin
    free_v = ~in_valid;
    if (ej_hit) free_v[ej_idx] = 1'b1;
  end

  // side-buffer injector, ahead of the local one
  logic          f1_hit, f2_hit;
  logic [IW-1:0] f1_idx, f2_idx;
  defl_low_free #(.NP(NPORTS)) u_free_sb (.mask(free_v), .hit(f1_hit), .idx(f1_idx));

  logic [CW-1:0] starve_cnt;
  logic          starved, sb_take, redirect, inj_take;
  assign starved  = (starve_cnt == LIMIT);
  assign sb_ready = f1_hit || starved;
  assign sb_take  = sb_valid && sb_ready;
  assign redirect = sb_take && !f1_hit;

  always_comb begin
    free_rest = free_v;
    if (sb_take && f1_hit) free_rest[f1_idx] = 1'b0;
  end

  defl_low_free #(.NP(NPORTS)) u_free_loc (.mask(free_rest), .hit(f2_hit), .idx(f2_idx));
  assign inj_ready = f2_hit;
  assign inj_take  = inj_valid && f2_hit;

  // next slot vector
  logic [NPORTS-1:0] nxt_v;
  flit_t             nxt_f [NPORTS];
  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      nxt_v[i] = in_valid[i] && !(ej_hit && ej_idx == IW'(i));
      nxt_f[i] = slot_f[i];
    end
    if (sb_take) begin
      nxt_v[f1_hit ? f1_idx : '0] = 1'b1;
      nxt_f[f1_hit ? f1_idx : '0] = flit_t'(sb_flit);
    end
    if (inj_take) begin
      nxt_v[f2_idx] = 1'b1;
      nxt_f[f2_idx] = flit_t'(inj_flit);
    end
    for (int i = 0; i < NPORTS; i++) begin
      if (nxt_f[i].age != '1) nxt_f[i].age = nxt_f[i].age + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      starve_cnt <= '0;
      out_valid  <= '0;
      out_flit   <= '0;
      ej_valid   <= 1'b0;
      ej_flit    <= '0;
      disp_valid <= 1'b0;
      disp_flit  <= '0;
    end else begin
      starve_cnt <= (sb_valid && !sb_ready) ? starve_cnt + 1'b1 : '0;
      out_valid  <= nxt_v;
      for (int i = 0; i < NPORTS; i++) out_flit[i] <= nxt_f[i];
      ej_valid   <= ej_hit;
      ej_flit    <= in_flit[ej_idx];
      disp_valid <= redirect;
      disp_flit  <= in_flit[0];
    end
  end
endmodule

// File: rtl/defl_eject_inject_chk.sv
module defl_eject_inject_chk import defl_ei_pkg::*; #(
  parameter int NPORTS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [COORD_W-1:0]            node_x,
  input logic [COORD_W-1:0]            node_y,
  input logic [NPORTS-1:0]             in_valid,
  input logic [NPORTS-1:0][FLIT_W-1:0] in_flit,
  input logic                          sb_valid,
  input logic                          sb_ready,
  input logic                          inj_valid,
  input logic                          inj_ready,
  input logic                          ej_valid,
  input logic [FLIT_W-1:0]             ej_flit,
  input logic                          disp_valid,
  input logic [NPORTS-1:0]             out_valid,
  input logic [NPORTS-1:0][FLIT_W-1:0] out_flit
);
  logic [NPORTS-1:0] here;
  for (genvar g = 0; g < NPORTS; g++) begin : g_here
    flit_t f;
    assign f       = flit_t'(in_flit[g]);
    assign here[g] = in_valid[g] && f.dx == node_x && f.dy == node_y;
  end
  flit_t ejf;
  assign ejf = flit_t'(ej_flit);

  // R1
  eject_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> (ejf.dx == node_x && ejf.dy == node_y));
  // R1
  eject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|here) |=> ej_valid);
  // R5
  sb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && inj_ready && sb_valid) |-> sb_ready);
  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&in_valid) && !(|here)) |-> !inj_ready);
  // R7
  disp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(sb_valid && sb_ready && (&in_valid)));

  for (genvar g = 0; g < NPORTS; g++) begin : g_age
    flit_t of;
    assign of = flit_t'(out_flit[g]);
    // R8
    age_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> (of.age != '0));
  end
endmodule

bind defl_eject_inject defl_eject_inject_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
  .in_valid(in_valid), .in_flit(in_flit), .sb_valid(sb_valid), .sb_ready(sb_ready),
  .inj_valid(inj_valid), .inj_ready(inj_ready), .ej_valid(ej_valid), .ej_flit(ej_flit),
  .disp_valid(disp_valid), .out_valid(out_valid), .out_flit(out_flit)
);

// File: tb/defl_eject_inject_test.sv
module defl_eject_inject_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int FW = 18;
  localparam logic [2:0] NX = 3'd2, NY = 3'd5;

  typedef struct packed {
    logic [3:0]  vin;
    logic [3:0]  loc;
    logic [15:0] ages;
    logic        sbv;
    logic        inv;
    logic [2:0]  ej;    // 4 = none
    logic        sbr;
    logic        injr;
    logic [3:0]  outv;
    logic [2:0]  sbs;   // 4 = none
    logic [2:0]  injs;  // 4 = none
  } vec_t;

  localparam vec_t [0:9] TBL = '{
    '{4'b0000, 4'b0000, 16'h0000, 1'b0, 1'b1, 3'd4, 1'b1, 1'b1, 4'b0001, 3'd4, 3'd0},
    '{4'b1111, 4'b0100, 16'h1111, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 4'b1111, 3'd2, 3'd4},
    '{4'b1111, 4'b1010, 16'h7151, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, 4'b1111, 3'd4, 3'd3},
    '{4'b1111, 4'b0110, 16'h1661, 1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 4'b1111, 3'd1, 3'd4},
    '{4'b0101, 4'b0000, 16'h0303, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, 4'b1111, 3'd1, 3'd3},
    '{4'b1111, 4'b0000, 16'hF0E2, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 4'b1111, 3'd4, 3'd4},
    '{4'b1001, 4'b1000, 16'h4001, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 4'b0001, 3'd4, 3'd4},
    '{4'b0000, 4'b0000, 16'h0000, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1, 4'b0001, 3'd0, 3'd4},
    '{4'b1110, 4'b0000, 16'h2220, 1'b1, 1'b1, 3'd4, 1'b1, 1'b0, 4'b1111, 3'd0, 3'd4},
    '{4'b1011, 4'b0011, 16'h0023, 1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 4'b1111, 3'd0, 3'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] in_valid = '0;
  logic [NP-1:0][FW-1:0] in_flit = '0;
  logic sb_valid = 1'b0, inj_valid = 1'b0;
  logic [FW-1:0] sb_flit = '0, inj_flit = '0;
  logic sb_ready, inj_ready, ej_valid, disp_valid;
  logic [FW-1:0] ej_flit, disp_flit;
  logic [NP-1:0] out_valid;
  logic [NP-1:0][FW-1:0] out_flit;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  defl_eject_inject uut (
    .clk(clk), .rst_n(rst_n), .node_x(NX), .node_y(NY),
    .in_valid(in_valid), .in_flit(in_flit),
    .sb_valid(sb_valid), .sb_flit(sb_flit), .sb_ready(sb_ready),
    .inj_valid(inj_valid), .inj_flit(inj_flit), .inj_ready(inj_ready),
    .ej_valid(ej_valid), .ej_flit(ej_flit),
    .disp_valid(disp_valid), .disp_flit(disp_flit),
    .out_valid(out_valid), .out_flit(out_flit)
  );

  function automatic logic [FW-1:0] mk(logic [2:0] x, logic [2:0] y, logic [3:0] a, logic [7:0] d);
    return {x, y, a, d};
  endfunction

  function automatic logic [FW-1:0] bump(logic [FW-1:0] f);
    logic [FW-1:0] r = f;
    if (f[11:8] != 4'hF) r[11:8] = f[11:8] + 4'd1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [FW-1:0] sbf, injf, expf;
    sbf  = mk(3'd3, 3'd3, 4'd2, 8'hA0);
    injf = mk(3'd4, 3'd4, 4'd0, 8'hB0);
    sb_flit  = sbf;
    inj_flit = injf;

    repeat (2) @(posedge clk);
    #1;
    chk("R9 out_valid in reset", 32'(out_valid), 0);
    chk("R9 ej_valid in reset", 32'(ej_valid), 0);
    chk("R9 disp_valid in reset", 32'(disp_valid), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      vec_t t = TBL[v];
      in_valid  = t.vin;
      sb_valid  = t.sbv;
      inj_valid = t.inv;
      for (int j = 0; j < NP; j++)
        in_flit[j] = mk(t.loc[j] ? NX : 3'd1, t.loc[j] ? NY : 3'd1,
                        t.ages[4*j +: 4], 8'h10 + 8'(j));
      @(negedge clk);
      chk("R4 sb_ready", 32'(sb_ready), 32'(t.sbr));
      chk(t.injr ? "R5 inj_ready" : "R6 inj_ready", 32'(inj_ready), 32'(t.injr));
      @(posedge clk);
      #1;
      chk("R1 ej_valid", 32'(ej_valid), 32'(t.ej != 3'd4));
      if (t.ej != 3'd4) chk("R2 ejected flit", 32'(ej_flit), 32'(in_flit[t.ej]));
      chk("R10 out_valid", 32'(out_valid), 32'(t.outv));
      chk("R7 no displacement", 32'(disp_valid), 0);
      for (int j = 0; j < NP; j++) begin
        if (t.outv[j]) begin
          if (3'(j) == t.sbs)       expf = bump(sbf);
          else if (3'(j) == t.injs) expf = bump(injf);
          else                      expf = bump(in_flit[j]);
          chk("R3/R8 slot flit", 32'(out_flit[j]), 32'(expf));
        end
      end
    end

    // saturation corner: vector 5 had slot3 age 15
    in_valid = 4'b0001;
    sb_valid = 1'b0;
    inj_valid = 1'b0;
    in_flit[0] = mk(3'd1, 3'd1, 4'hF, 8'h55);
    @(posedge clk);
    #1;
    chk("R8 age saturates", 32'(out_flit[0][11:8]), 32'hF);

    // redirection: all slots full, nothing local, side buffer waiting
    in_valid = 4'b1111;
    for (int j = 0; j < NP; j++) in_flit[j] = mk(3'd1, 3'd1, 4'd1, 8'h20 + 8'(j));
    sb_valid = 1'b1;
    inj_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 sb_ready timing", 32'(sb_ready), 32'(k == 3));
      chk("R6 inj_ready full", 32'(inj_ready), 0);
      @(posedge clk);
      #1;
      chk("R7 disp_valid", 32'(disp_valid), 32'(k == 3));
      if (k == 3) begin
        chk("R7 displaced flit", 32'(disp_flit), 32'(in_flit[0]));
        chk("R7 slot0 gets sb flit", 32'(out_flit[0]), 32'(bump(sbf)));
        chk("R3 slot1 kept", 32'(out_flit[1]), 32'(bump(in_flit[1])));
      end else begin
        chk("R3 slot0 kept", 32'(out_flit[0]), 32'(bump(in_flit[0])));
      end
    end
    sb_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R7 disp clears", 32'(disp_valid), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule